// File: doc/BRIEF.md
# Interrupt Source Controller

This block is the source side of a two-layer interrupt scheme. It owns a set of interrupt inputs, each with its own number, a target server, a priority and a type: edge (message-signalled) or level-sensitive. It turns input activity into delivery requests for the presentation layer. Each request carries a server, a source number and a priority, and the block issues at most one request per cycle.

The presentation layer answers through two strobes, each tagged with a source number. A reject strobe hands a delivery back to the block. An end-of-interrupt strobe retires a delivery. A resend request makes the block walk all of its sources and offer again whatever is still owed. A configuration port lets software set or read a source's server and priority, and each access returns a status code. A priority of 0xFF masks a source. Edge sources that fire while masked are remembered, and they are delivered once they are unmasked.

Top module: `irq_source_ctrl`

## Requirements
- R1: Source numbers run from SRC_BASE to SRC_BASE+NUM_SRC-1, and source index i reports number SRC_BASE+i on `dlv_num`. Numbers outside that range are ignored by the reject and EOI strobes and rejected by the configuration port.
- R2: A configuration access raises `cfg_done` on the following cycle. A write returns status 0x00 and updates server and priority when three conditions all hold: the number is valid, `cfg_server` is below NUM_SERVERS, and `cfg_prio` is at most 0xFF. Otherwise the write returns 0xFD (-3) and changes nothing. A read returns 0x00 with the stored server and priority, or 0xFD for an invalid number.
- R3: A source whose priority is 0xFF is never delivered.
- R4: On a rising input, an unmasked edge source is delivered: `dlv_valid` is high two clock edges after the input rises. If the source is masked, it records a pending flag instead. A later write that sets a priority other than 0xFF clears that flag and delivers the source.
- R5: A level source is delivered when it is unmasked, its input is high and its sent flag is clear. Each such evaluation sets the sent flag. Evaluation happens when the input rises, when the source is written, and during a resend scan. While the sent flag is set, the source is not delivered again.
- R6: A reject sets the source's rejected flag and clears its sent flag. An EOI clears the sent flag of a level source only. Neither strobe delivers anything by itself.
- R7: A resend request starts a scan that visits one source per cycle, and `resend_busy` is high while the scan runs. A rejected edge source has its rejected flag cleared, and it is delivered if it is unmasked. A level source is re-evaluated as in R5. A request that arrives during a scan causes one more scan.
- R8: When several sources want delivery, the lowest index is delivered first, one per cycle. The other sources stay flagged and are delivered in later cycles.
- R9: Reset sets every server to 0 and every priority to 0xFF, and it clears all per-source flags. The type of each source comes from `src_is_level` and is not affected by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | NUM_SRC | Interrupt inputs, one per source |
| src_is_level | input | NUM_SRC | Source type: 1 = level, 0 = edge |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_num | input | NUM_W | Source number for the access |
| cfg_server | input | SRV_W | Server to write |
| cfg_prio | input | PRIO_IN_W | Priority to write (values above 0xFF are invalid) |
| cfg_done | output | 1 | Access response valid |
| cfg_status | output | 8 | 0x00 success, 0xFD error |
| cfg_rd_server | output | SRV_W | Server returned by a read |
| cfg_rd_prio | output | 8 | Priority returned by a read |
| rej_valid | input | 1 | Reject strobe |
| rej_num | input | NUM_W | Source number being rejected |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_num | input | NUM_W | Source number being retired |
| resend_req | input | 1 | Start a resend scan |
| resend_busy | output | 1 | Resend scan in progress |
| dlv_valid | output | 1 | Delivery valid |
| dlv_server | output | SRV_W | Target server of the delivery |
| dlv_num | output | NUM_W | Source number of the delivery |
| dlv_prio | output | 8 | Priority of the delivery |

## Verification
The bench builds the block with NUM_SRC=4, NUM_SERVERS=2 and SRC_BASE=16. Sources 16 and 17 are edge sources, and sources 18 and 19 are level sources. With so few sources, every error condition of the configuration port is reachable in a handful of writes: a number below the range, a number above it, server 2 and priority 0x100. A resend scan finishes in four cycles, so the bench can compare a rejected edge source, a level source retired by EOI and a level source that is still marked sent within a single short run. Two edge sources firing together show the lowest-first ordering in consecutive cycles.

// File: rtl/irq_src_pkg.sv
// Shared types and constants of the interrupt source controller.
package irq_src_pkg;
    localparam int PRIO_W = 8;
    typedef logic [PRIO_W-1:0] prio_t;
    localparam prio_t      PRIO_MASKED = 8'hFF;
    localparam logic [7:0] STAT_OK     = 8'h00;
    localparam logic [7:0] STAT_BAD    = 8'hFD;
endpackage

// File: rtl/irq_src_slot.sv
// One interrupt source: holds its server, its priority and the flags that
// track edge and level delivery. Assumes every strobe input has already been
// decoded to this slot and is valid.
module irq_src_slot
    import irq_src_pkg::*;
#(
    parameter int SRV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             is_level,
    input  logic             level_in,
    input  logic             wr_hit,
    input  logic [SRV_W-1:0] wr_server,
    input  prio_t            wr_prio,
    input  logic             rej_hit,
    input  logic             eoi_hit,
    input  logic             scan_hit,
    input  logic             grant,
    output logic             req,
    output logic [SRV_W-1:0] server,
    output prio_t            prio
);
    logic [SRV_W-1:0] srv_q, n_srv;
    prio_t            prio_q, n_prio;
    logic             want_q, n_want, sent_q, n_sent, rej_q, n_rej, mp_q, n_mp;
    logic             seen_q, rise, unmasked;

    assign rise = level_in & ~seen_q;

    // Work out the next state from the strobes, in a fixed order.
    always_comb begin
        n_srv  = srv_q;
        n_prio = prio_q;
        n_want = want_q;
        n_sent = sent_q;
        n_rej  = rej_q;
        n_mp   = mp_q;
        if (grant) n_want = 1'b0;
        if (rej_hit) begin
            n_rej  = 1'b1;
            n_sent = 1'b0;
        end
        if (eoi_hit && is_level) n_sent = 1'b0;
        if (wr_hit) begin
            n_srv  = wr_server;
            n_prio = wr_prio;
        end
        unmasked = (n_prio != PRIO_MASKED);
        if (is_level) begin
            if ((wr_hit || rise || scan_hit) && unmasked && level_in && !n_sent) begin
                n_sent = 1'b1;
                n_want = 1'b1;
            end
        end else begin
            if (rise) begin
                if (unmasked) n_want = 1'b1;
                else          n_mp   = 1'b1;
            end
            if (wr_hit && n_mp && unmasked) begin
                n_mp   = 1'b0;
                n_want = 1'b1;
            end
            if (scan_hit && n_rej) begin
                n_rej = 1'b0;
                if (unmasked) n_want = 1'b1;
            end
        end
    end

    // Register the source state; reset leaves the source masked and idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            srv_q  <= '0;
            prio_q <= PRIO_MASKED;
            want_q <= 1'b0;
            sent_q <= 1'b0;
            rej_q  <= 1'b0;
            mp_q   <= 1'b0;
            seen_q <= 1'b0;
        end else begin
            srv_q  <= n_srv;
            prio_q <= n_prio;
            want_q <= n_want;
            sent_q <= n_sent;
            rej_q  <= n_rej;
            mp_q   <= n_mp;
            seen_q <= level_in;
        end
    end

    assign req    = want_q && (prio_q != PRIO_MASKED);
    assign server = srv_q;
    assign prio   = prio_q;
endmodule

// File: rtl/irq_resend_scan.sv
// Resend walker: visits one source index per cycle while busy. Assumes
// NUM_SRC >= 2. A request that arrives mid-scan queues one more full scan.
module irq_resend_scan #(
    parameter int NUM_SRC = 8,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SRC - 1);
    logic again_q;

    // Step the scan index and handle requests that arrive while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            idx     <= '0;
            again_q <= 1'b0;
        end else if (!busy) begin
            busy <= start;
            idx  <= '0;
        end else begin
            if (start) again_q <= 1'b1;
            if (idx == LAST) begin
                idx     <= '0;
                busy    <= again_q || start;
                again_q <= 1'b0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_lowest_arb.sv
// Fixed-priority picker: the lowest requesting index wins. Purely combinational.
module irq_lowest_arb #(
    parameter int NUM_SRC = 8,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] req,
    output logic               any,
    output logic [IDX_W-1:0]   idx,
    output logic [NUM_SRC-1:0] gnt
);
    // Scan from the top down so that the lowest set bit is the one that stays.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
        gnt = any ? (NUM_SRC'(1) << idx) : '0;
    end
endmodule

// File: rtl/irq_source_ctrl.sv
// Interrupt source controller top. Decodes the source-numbered strobes and
// configuration accesses, holds one slot per source, runs the resend scan and
// issues one registered delivery per cycle, lowest source first. Assumes
// src_is_level is static while the block runs.
module irq_source_ctrl
    import irq_src_pkg::*;
#(
    parameter int NUM_SRC     = 8,
    parameter int NUM_SERVERS = 4,
    parameter int SRC_BASE    = 16,
    parameter int NUM_W       = 16,
    parameter int SRV_W       = 8,
    parameter int PRIO_IN_W   = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   src_in,
    input  logic [NUM_SRC-1:0]   src_is_level,
    input  logic                 cfg_wr,
    input  logic                 cfg_rd,
    input  logic [NUM_W-1:0]     cfg_num,
    input  logic [SRV_W-1:0]     cfg_server,
    input  logic [PRIO_IN_W-1:0] cfg_prio,
    output logic                 cfg_done,
    output logic [7:0]           cfg_status,
    output logic [SRV_W-1:0]     cfg_rd_server,
    output logic [7:0]           cfg_rd_prio,
    input  logic                 rej_valid,
    input  logic [NUM_W-1:0]     rej_num,
    input  logic                 eoi_valid,
    input  logic [NUM_W-1:0]     eoi_num,
    input  logic                 resend_req,
    output logic                 resend_busy,
    output logic                 dlv_valid,
    output logic [SRV_W-1:0]     dlv_server,
    output logic [NUM_W-1:0]     dlv_num,
    output logic [7:0]           dlv_prio
);
    localparam int IDX_W = $clog2(NUM_SRC);

    function automatic logic in_range(input logic [NUM_W-1:0] n);
        return (32'(n) >= 32'(SRC_BASE)) && (32'(n) < 32'(SRC_BASE + NUM_SRC));
    endfunction

    function automatic logic [IDX_W-1:0] to_idx(input logic [NUM_W-1:0] n);
        return IDX_W'(n - NUM_W'(SRC_BASE));
    endfunction

    logic                            num_ok, wr_ok, arb_any, scan_busy;
    logic [IDX_W-1:0]                cfg_idx, rej_idx, eoi_idx, arb_idx, scan_idx;
    logic [NUM_SRC-1:0]              req_all, gnt_all;
    logic [NUM_SRC-1:0][SRV_W-1:0]   srv_all;
    logic [NUM_SRC-1:0][7:0]         prio_all;

    assign num_ok  = in_range(cfg_num);
    assign wr_ok   = num_ok && (32'(cfg_server) < 32'(NUM_SERVERS)) && (32'(cfg_prio) <= 32'd255);
    assign cfg_idx = to_idx(cfg_num);
    assign rej_idx = to_idx(rej_num);
    assign eoi_idx = to_idx(eoi_num);

    irq_resend_scan #(.NUM_SRC(NUM_SRC)) u_scan (
        .clk(clk), .rst_n(rst_n), .start(resend_req), .busy(scan_busy), .idx(scan_idx)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_slot
        irq_src_slot #(.SRV_W(SRV_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .is_level (src_is_level[i]),
            .level_in (src_in[i]),
            .wr_hit   (cfg_wr && wr_ok && (cfg_idx == IDX_W'(i))),
            .wr_server(cfg_server),
            .wr_prio  (cfg_prio[7:0]),
            .rej_hit  (rej_valid && in_range(rej_num) && (rej_idx == IDX_W'(i))),
            .eoi_hit  (eoi_valid && in_range(eoi_num) && (eoi_idx == IDX_W'(i))),
            .scan_hit (scan_busy && (scan_idx == IDX_W'(i))),
            .grant    (gnt_all[i]),
            .req      (req_all[i]),
            .server   (srv_all[i]),
            .prio     (prio_all[i])
        );
    end

    irq_lowest_arb #(.NUM_SRC(NUM_SRC)) u_arb (
        .req(req_all), .any(arb_any), .idx(arb_idx), .gnt(gnt_all)
    );

    assign resend_busy = scan_busy;

    // Register the granted delivery toward the presentation layer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dlv_valid  <= 1'b0;
            dlv_server <= '0;
            dlv_num    <= '0;
            dlv_prio   <= '0;
        end else begin
            dlv_valid  <= arb_any;
            dlv_server <= srv_all[arb_idx];
            dlv_num    <= NUM_W'(SRC_BASE) + NUM_W'(arb_idx);
            dlv_prio   <= prio_all[arb_idx];
        end
    end

    // Answer configuration accesses one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_done      <= 1'b0;
            cfg_status    <= STAT_OK;
            cfg_rd_server <= '0;
            cfg_rd_prio   <= '0;
        end else begin
            cfg_done      <= cfg_wr || cfg_rd;
            cfg_status    <= (cfg_wr ? wr_ok : num_ok) ? STAT_OK : STAT_BAD;
            cfg_rd_server <= (cfg_rd && num_ok) ? srv_all[cfg_idx] : '0;
            cfg_rd_prio   <= (cfg_rd && num_ok) ? prio_all[cfg_idx] : '0;
        end
    end
endmodule

// File: rtl/irq_source_ctrl_chk.sv
// Property checker for the interrupt source controller, bound to the top.
module irq_source_ctrl_chk #(
    parameter int NUM_SRC     = 8,
    parameter int NUM_SERVERS = 4,
    parameter int SRC_BASE    = 16,
    parameter int NUM_W       = 16,
    parameter int SRV_W       = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr,
    input logic             cfg_rd,
    input logic             cfg_done,
    input logic [7:0]       cfg_status,
    input logic             resend_req,
    input logic             resend_busy,
    input logic             dlv_valid,
    input logic [SRV_W-1:0] dlv_server,
    input logic [NUM_W-1:0] dlv_num,
    input logic [7:0]       dlv_prio
);
    assert_masked_never_sent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> (dlv_prio != 8'hFF));

    assert_num_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> ((32'(dlv_num) >= 32'(SRC_BASE)) && (32'(dlv_num) < 32'(SRC_BASE + NUM_SRC))));

    assert_server_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> (32'(dlv_server) < 32'(NUM_SERVERS)));

    assert_cfg_answer_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr || cfg_rd) |=> cfg_done);

    assert_cfg_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |-> ((cfg_status == 8'h00) || (cfg_status == 8'hFD)));

    assert_scan_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (resend_req && !resend_busy) |=> resend_busy);
endmodule

bind irq_source_ctrl irq_source_ctrl_chk #(
    .NUM_SRC(NUM_SRC), .NUM_SERVERS(NUM_SERVERS), .SRC_BASE(SRC_BASE),
    .NUM_W(NUM_W), .SRV_W(SRV_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_done(cfg_done), .cfg_status(cfg_status),
    .resend_req(resend_req), .resend_busy(resend_busy),
    .dlv_valid(dlv_valid), .dlv_server(dlv_server),
    .dlv_num(dlv_num), .dlv_prio(dlv_prio)
);

// File: tb/tb_irq_source_ctrl.sv
module tb_irq_source_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NS-1:0] src_in = '0;
    logic [NS-1:0] src_is_level = 4'b1100;
    logic cfg_wr = 0, cfg_rd = 0, rej_valid = 0, eoi_valid = 0, resend_req = 0;
    logic [15:0] cfg_num = '0, rej_num = '0, eoi_num = '0;
    logic [7:0]  cfg_server = '0;
    logic [15:0] cfg_prio = '0;
    logic cfg_done, resend_busy, dlv_valid;
    logic [7:0] cfg_status, cfg_rd_server, cfg_rd_prio, dlv_server, dlv_prio;
    logic [15:0] dlv_num;

    irq_source_ctrl #(.NUM_SRC(NS), .NUM_SERVERS(2), .SRC_BASE(16)) dut (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .src_is_level(src_is_level),
        .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_num(cfg_num), .cfg_server(cfg_server),
        .cfg_prio(cfg_prio), .cfg_done(cfg_done), .cfg_status(cfg_status),
        .cfg_rd_server(cfg_rd_server), .cfg_rd_prio(cfg_rd_prio),
        .rej_valid(rej_valid), .rej_num(rej_num), .eoi_valid(eoi_valid), .eoi_num(eoi_num),
        .resend_req(resend_req), .resend_busy(resend_busy),
        .dlv_valid(dlv_valid), .dlv_server(dlv_server), .dlv_num(dlv_num), .dlv_prio(dlv_prio)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Delivery log, sampled away from the active edge.
    int dcount = 0;
    int lg_num [0:63];
    int lg_srv [0:63];
    int lg_prio[0:63];
    int lg_cyc [0:63];
    always @(negedge clk) begin
        if (rst_n && dlv_valid && dcount < 64) begin
            lg_num[dcount]  = int'(dlv_num);
            lg_srv[dcount]  = int'(dlv_server);
            lg_prio[dcount] = int'(dlv_prio);
            lg_cyc[dcount]  = cyc;
            dcount = dcount + 1;
        end
    end

    int checks = 0, failures = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    logic [7:0] r_st, r_srv, r_prio;

    task automatic access(input bit wr, input logic [15:0] num, input logic [7:0] srv,
                          input logic [15:0] prio);
        cfg_wr = wr; cfg_rd = !wr; cfg_num = num; cfg_server = srv; cfg_prio = prio;
        @(negedge clk);
        cfg_wr = 0; cfg_rd = 0;
        chk(cfg_done, "R2 done", int'(cfg_done), 1);
        r_st = cfg_status; r_srv = cfg_rd_server; r_prio = cfg_rd_prio;
    endtask

    task automatic pulse_rej(input logic [15:0] n);
        rej_valid = 1; rej_num = n; @(negedge clk); rej_valid = 0;
    endtask

    task automatic pulse_eoi(input logic [15:0] n);
        eoi_valid = 1; eoi_num = n; @(negedge clk); eoi_valid = 0;
    endtask

    task automatic pulse_resend();
        resend_req = 1; @(negedge clk); resend_req = 0;
    endtask

    // Fields: number[47:32] server[31:24] priority[23:8] expected status[7:0]
    localparam logic [47:0] CFG_VEC [0:5] = '{
        48'h0010_01_0040_00,
        48'h0011_00_0020_00,
        48'h000F_00_0005_FD,
        48'h0014_00_0005_FD,
        48'h0010_02_0005_FD,
        48'h0010_00_0100_FD
    };

    initial begin
        int base, k;
        idle(3);
        rst_n = 1;
        idle(1);

        // R9: reset state of every source
        for (int n = 16; n < 20; n++) begin
            access(0, 16'(n), 0, 0);
            chk(r_st == 8'h00, "R9 status", int'(r_st), 0);
            chk(r_srv == 8'h00, "R9 server", int'(r_srv), 0);
            chk(r_prio == 8'hFF, "R9 prio", int'(r_prio), 255);
        end
        access(0, 16'd20, 0, 0);
        chk(r_st == 8'hFD, "R1 read invalid", int'(r_st), 253);

        // R2: configuration vector table
        for (int v = 0; v < 6; v++) begin
            access(1, CFG_VEC[v][47:32], CFG_VEC[v][31:24], CFG_VEC[v][23:8]);
            chk(r_st == CFG_VEC[v][7:0], "R2 write status", int'(r_st), int'(CFG_VEC[v][7:0]));
        end
        access(0, 16'd16, 0, 0);
        chk(r_srv == 8'd1 && r_prio == 8'h40, "R2 failed writes kept", int'(r_prio), 64);
        access(0, 16'd17, 0, 0);
        chk(r_srv == 8'd0 && r_prio == 8'h20, "R2 readback", int'(r_prio), 32);
        chk(dcount == 0, "R4 no delivery without event", dcount, 0);

        // R4 and R1: unmasked edge source
        base = dcount; k = cyc;
        src_in[0] = 1;
        idle(5);
        chk(dcount - base == 1, "R4 edge count", dcount - base, 1);
        chk(lg_num[base] == 16, "R1 number", lg_num[base], 16);
        chk(lg_srv[base] == 1 && lg_prio[base] == 64, "R4 fields", lg_prio[base], 64);
        chk(lg_cyc[base] == k + 2, "R4 latency", lg_cyc[base] - k, 2);
        src_in[0] = 0;

        // R3 and R4: masked edge held pending, released by unmask
        access(1, 16'd17, 0, 16'h00FF);
        base = dcount;
        src_in[1] = 1; idle(2); src_in[1] = 0; idle(4);
        chk(dcount == base, "R3 masked edge", dcount - base, 0);
        access(1, 16'd17, 0, 16'h0022);
        idle(4);
        chk(dcount - base == 1 && lg_num[base] == 17 && lg_prio[base] == 34,
            "R4 pending released", dcount - base, 1);

        // R5: level source masked, then written unmasked
        base = dcount;
        src_in[2] = 1; idle(4);
        chk(dcount == base, "R3 masked level", dcount - base, 0);
        access(1, 16'd18, 1, 16'h0010);
        idle(4);
        chk(dcount - base == 1 && lg_num[base] == 18 && lg_srv[base] == 1,
            "R5 level on write", dcount - base, 1);
        idle(6);
        chk(dcount - base == 1, "R5 sent holds", dcount - base, 1);

        // R6: EOI clears sent without delivering; R7 resend then redelivers
        base = dcount;
        pulse_eoi(16'd18); idle(4);
        chk(dcount == base, "R6 eoi silent", dcount - base, 0);
        pulse_resend();
        chk(resend_busy == 1'b1, "R7 busy", int'(resend_busy), 1);
        idle(8);
        chk(resend_busy == 1'b0, "R7 scan ends", int'(resend_busy), 0);
        chk(dcount - base == 1 && lg_num[base] == 18, "R7 level resent", dcount - base, 1);

        // R6 and R7: reject of the level source, then resend
        base = dcount;
        pulse_rej(16'd18); idle(3);
        chk(dcount == base, "R6 reject silent", dcount - base, 0);
        pulse_resend(); idle(8);
        chk(dcount - base == 1 && lg_num[base] == 18, "R7 rejected level", dcount - base, 1);

        // R7: rejected edge source redelivered exactly once
        base = dcount;
        pulse_rej(16'd16); pulse_rej(16'd30); idle(2);
        pulse_resend(); idle(8);
        chk(dcount - base == 1 && lg_num[base] == 16 && lg_prio[base] == 64,
            "R7 edge resent", dcount - base, 1);
        base = dcount;
        pulse_resend(); idle(8);
        chk(dcount == base, "R7 reject flag cleared", dcount - base, 0);

        // R8: two edges at once, lowest first on consecutive cycles
        base = dcount;
        src_in[1:0] = 2'b11; idle(6); src_in[1:0] = 2'b00;
        chk(dcount - base == 2, "R8 count", dcount - base, 2);
        chk(lg_num[base] == 16 && lg_num[base+1] == 17, "R8 order", lg_num[base], 16);
        chk(lg_cyc[base+1] == lg_cyc[base] + 1, "R8 back to back",
            lg_cyc[base+1] - lg_cyc[base], 1);

        // R9: reset mid-run clears configuration and the sent flag
        rst_n = 0; idle(2); rst_n = 1; idle(1);
        access(0, 16'd18, 0, 0);
        chk(r_srv == 8'd0 && r_prio == 8'hFF, "R9 after reset", int'(r_prio), 255);
        base = dcount;
        access(1, 16'd18, 0, 16'h0030);
        idle(4);
        chk(dcount - base == 1 && lg_num[base] == 18 && lg_prio[base] == 48,
            "R9 sent cleared", dcount - base, 1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule